// File: doc/BRIEF.md
# Double-Buffered Video Processing Amplifier

This block adjusts a stream of 8-bit component video samples. Luma is multiplied by a contrast gain and then shifted by a signed brightness offset. Both chroma components are scaled around their mid-scale value of 128 by one shared saturation gain. Every result is limited to the legal code range 1 to 254. After the arithmetic stage, luma and chroma pass through separate delay lines. Each delay is set in clock cycles, so the two paths can be aligned with whatever follows.

Settings are written through a small register port into a shadow bank. When double buffering is off, each write reaches the active bank at once. When it is on, the shadow bank is copied to the active bank only when a start-of-field sample arrives. This lets software update a whole set of values during a field without producing a partial update on screen.

Top module: `vid_procamp`

## Requirements
- R1: Luma output equals floor(Y * G / 128) + S, limited to 1..254. G is the contrast register at address 0, an unsigned gain where 0x80 is unity.
- R2: S is the setup register at address 1, read as an 8-bit two's complement offset (-128..127).
- R3: Each chroma output equals floor((C - 128) * K / 128) + 128, limited to 1..254. K is the saturation register at address 2, an unsigned gain where 0x80 is unity, shared by Cb and Cr. The floor rounds toward negative infinity.
- R4: Every valid output sample lies in 1..254, whatever the inputs and gains.
- R5: With dbuf_en high, writes change only the shadow bank. The gains and setup apply from the first sample that has in_valid and in_sof both high. Samples before it keep the previous values.
- R6: With dbuf_en low, a write taken at a clock edge applies to every sample captured at later edges.
- R7: Address 3 bits [3:0] set the luma delay DY. Values above 6 act as 6. A luma sample captured at edge n appears on out_y after edge n+1+DY.
- R8: Address 3 bits [7:4] set the chroma delay DC. Values above 8 act as 8. A chroma sample captured at edge n appears on out_cb/out_cr after edge n+1+DC.
- R9: After reset, contrast and saturation are 0x80 and setup and both delays are 0. Both output strobes are low until a valid sample has passed through.
- R10: out_y_vld and out_c_vld are in_valid delayed by 1+DY and 1+DC cycles. A cycle with in_valid low gives a low strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sof | input | 1 | Start-of-field marker, qualified by in_valid |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference sample, offset 128 |
| in_cr | input | 8 | Red-difference sample, offset 128 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 contrast, 1 setup, 2 saturation, 3 delays |
| wr_data | input | 8 | Register write data |
| dbuf_en | input | 1 | Double buffering enable |
| out_y_vld | output | 1 | Luma output strobe |
| out_y | output | 8 | Adjusted, delayed luma |
| out_c_vld | output | 1 | Chroma output strobe |
| out_cb | output | 8 | Adjusted, delayed Cb |
| out_cr | output | 8 | Adjusted, delayed Cr |

## Verification
A luma result is due 1+DY rising edges after the edge that captured its sample, and a chroma result 1+DC edges after it. DY and DC are taken from the active bank after the edge being checked. The bench keeps the expected results and strobes in a history indexed by capture cycle. At each falling edge it compares the outputs with the entry that lies 1+DY or 1+DC cycles back, so a delay change is seen at the first edge after it takes hold. The bench's bank model makes a gain write count from the following capture edge when double buffering is off. When it is on, the write counts from the start-of-field sample.

// File: rtl/procamp_pkg.sv
package procamp_pkg;

  localparam int PIX_W     = 8;
  localparam int GAIN_W    = 8;
  localparam int GAIN_FRAC = 7;
  localparam int DLY_W     = 4;
  localparam int ADDR_W    = 2;
  localparam int PROD_W    = PIX_W + GAIN_W;
  localparam int WIDE_W    = 20;

  localparam logic [ADDR_W-1:0] A_CONTRAST = 2'd0;
  localparam logic [ADDR_W-1:0] A_SETUP    = 2'd1;
  localparam logic [ADDR_W-1:0] A_SAT      = 2'd2;
  localparam logic [ADDR_W-1:0] A_DELAY    = 2'd3;

  localparam logic signed [WIDE_W-1:0] PIX_LO = 20'sd1;
  localparam logic signed [WIDE_W-1:0] PIX_HI = 20'sd254;
  localparam logic signed [WIDE_W-1:0] C_MID  = 20'sd128;

  typedef struct packed {
    logic [GAIN_W-1:0] contrast;
    logic [PIX_W-1:0]  setup;
    logic [GAIN_W-1:0] sat;
    logic [DLY_W-1:0]  dly_c;
    logic [DLY_W-1:0]  dly_y;
  } amp_cfg_t;

  localparam amp_cfg_t CFG_RST = '{contrast: 8'h80, setup: 8'h00, sat: 8'h80,
                                   dly_c: 4'd0, dly_y: 4'd0};

  function automatic logic [PIX_W-1:0] clamp_pix(input logic signed [WIDE_W-1:0] v);
    logic signed [WIDE_W-1:0] t;
    t = v;
    if (v < PIX_LO) t = PIX_LO;
    else if (v > PIX_HI) t = PIX_HI;
    return t[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/procamp_regs.sv
module procamp_regs
  import procamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic              dbuf_en,
  input  logic              field_start,
  output amp_cfg_t          cfg_eff,
  output logic [DLY_W-1:0]  dly_y_act,
  output logic [DLY_W-1:0]  dly_c_act
);

  amp_cfg_t shadow_q, shadow_d;
  amp_cfg_t active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) begin
      case (wr_addr)
        A_CONTRAST: shadow_d.contrast = wr_data;
        A_SETUP:    shadow_d.setup    = wr_data;
        A_SAT:      shadow_d.sat      = wr_data;
        default: begin
          shadow_d.dly_y = wr_data[DLY_W-1:0];
          shadow_d.dly_c = wr_data[2*DLY_W-1:DLY_W];
        end
      endcase
    end
  end

  always_comb begin
    if (!dbuf_en)        active_d = shadow_d;
    else if (field_start) active_d = shadow_q;
    else                 active_d = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= CFG_RST;
      active_q <= CFG_RST;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  // the first sample of a new field already sees the pending bank
  assign cfg_eff   = (dbuf_en && field_start) ? shadow_q : active_q;
  assign dly_y_act = active_q.dly_y;
  assign dly_c_act = active_q.dly_c;

  // R5: active settings frozen between field starts while buffering
  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !field_start) |=> $stable(active_q));

  // R6: unbuffered writes reach the active bank at the same edge
  p_direct_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && wr_en && wr_addr == A_CONTRAST) |=> active_q.contrast == $past(wr_data));

endmodule

// File: rtl/procamp_arith.sv
module procamp_arith
  import procamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  amp_cfg_t         cfg,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_cr,
  output logic             res_vld,
  output logic [PIX_W-1:0] res_y,
  output logic [PIX_W-1:0] res_cb,
  output logic [PIX_W-1:0] res_cr
);

  logic [PROD_W-1:0]        y_prod;
  logic signed [WIDE_W-1:0] y_sum;
  logic [PIX_W-1:0]         y_d;
  logic [PIX_W-1:0]         c_in [2];
  logic [PIX_W-1:0]         c_d  [2];
  logic [PIX_W-1:0]         c_q  [2];

  always_comb begin
    y_prod = {{GAIN_W{1'b0}}, in_y} * {{PIX_W{1'b0}}, cfg.contrast};
    y_sum  = $signed({{(WIDE_W-PROD_W){1'b0}}, y_prod >> GAIN_FRAC})
           + $signed({{(WIDE_W-PIX_W){cfg.setup[PIX_W-1]}}, cfg.setup});
    y_d    = clamp_pix(y_sum);
  end

  assign c_in[0] = in_cb;
  assign c_in[1] = in_cr;

  for (genvar i = 0; i < 2; i++) begin : g_chroma
    logic signed [WIDE_W-1:0] diff, prod, sum;
    always_comb begin
      diff   = $signed({{(WIDE_W-PIX_W){1'b0}}, c_in[i]}) - C_MID;
      prod   = diff * $signed({{(WIDE_W-GAIN_W){1'b0}}, cfg.sat});
      sum    = (prod >>> GAIN_FRAC) + C_MID;
      c_d[i] = clamp_pix(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        c_q[i] <= '0;
      else if (in_valid) c_q[i] <= c_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_y   <= '0;
    end else begin
      res_vld <= in_valid;
      if (in_valid) res_y <= y_d;
    end
  end

  assign res_cb = c_q[0];
  assign res_cr = c_q[1];

  // R1: unity contrast and zero setup pass luma through within range
  p_unity_luma_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg.contrast == 8'h80 && cfg.setup == 8'h00 && in_y >= 8'd1 && in_y <= 8'd254)
    |=> res_y == $past(in_y));

endmodule

// File: rtl/procamp_dly.sv
module procamp_dly
  import procamp_pkg::*;
#(
  parameter int MAX = 6,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] sel,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  output logic             out_vld,
  output logic [W-1:0]     out_data
);

  localparam logic [DLY_W-1:0] MAX_SEL = DLY_W'(MAX);

  logic [W-1:0]     tap_d [MAX+1];
  logic             tap_v [MAX+1];
  logic [DLY_W-1:0] sel_c;

  assign tap_d[0] = in_data;
  assign tap_v[0] = in_vld;

  for (genvar k = 1; k <= MAX; k++) begin : g_stage
    logic [W-1:0] d_nxt;
    logic         v_nxt;
    always_comb begin
      v_nxt = tap_v[k-1];
      d_nxt = tap_d[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_v[k] <= 1'b0;
        tap_d[k] <= '0;
      end else begin
        tap_v[k] <= v_nxt;
        if (v_nxt) tap_d[k] <= d_nxt;
      end
    end
  end

  assign sel_c = (sel > MAX_SEL) ? MAX_SEL : sel;

  always_comb begin
    out_vld  = tap_v[0];
    out_data = tap_d[0];
    for (int k = 1; k <= MAX; k++) begin
      if (sel_c == DLY_W'(k)) begin
        out_vld  = tap_v[k];
        out_data = tap_d[k];
      end
    end
  end

endmodule

// File: rtl/vid_procamp.sv
module vid_procamp
  import procamp_pkg::*;
#(
  parameter int Y_DLY_MAX = 6,
  parameter int C_DLY_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [PIX_W-1:0]  in_y,
  input  logic [PIX_W-1:0]  in_cb,
  input  logic [PIX_W-1:0]  in_cr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic              dbuf_en,
  output logic              out_y_vld,
  output logic [PIX_W-1:0]  out_y,
  output logic              out_c_vld,
  output logic [PIX_W-1:0]  out_cb,
  output logic [PIX_W-1:0]  out_cr
);

  localparam int C_W = 2 * PIX_W;

  amp_cfg_t         cfg_eff;
  logic [DLY_W-1:0] dly_y_act, dly_c_act;
  logic             res_vld;
  logic [PIX_W-1:0] res_y, res_cb, res_cr;
  logic [C_W-1:0]   c_pair;
  logic             armed;

  procamp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dbuf_en    (dbuf_en),
    .field_start(in_valid && in_sof),
    .cfg_eff    (cfg_eff),
    .dly_y_act  (dly_y_act),
    .dly_c_act  (dly_c_act)
  );

  procamp_arith u_arith (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg_eff),
    .in_valid(in_valid),
    .in_y    (in_y),
    .in_cb   (in_cb),
    .in_cr   (in_cr),
    .res_vld (res_vld),
    .res_y   (res_y),
    .res_cb  (res_cb),
    .res_cr  (res_cr)
  );

  procamp_dly #(.MAX(Y_DLY_MAX), .W(PIX_W)) u_ydly (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (dly_y_act),
    .in_vld  (res_vld),
    .in_data (res_y),
    .out_vld (out_y_vld),
    .out_data(out_y)
  );

  procamp_dly #(.MAX(C_DLY_MAX), .W(C_W)) u_cdly (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (dly_c_act),
    .in_vld  (res_vld),
    .in_data ({res_cr, res_cb}),
    .out_vld (out_c_vld),
    .out_data(c_pair)
  );

  assign out_cb = c_pair[PIX_W-1:0];
  assign out_cr = c_pair[C_W-1:PIX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4: luma stays inside the legal code range
  p_y_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_y_vld |-> (out_y >= 8'd1 && out_y <= 8'd254));

  // R4: chroma stays inside the legal code range
  p_c_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_c_vld |-> (out_cb >= 8'd1 && out_cb <= 8'd254 && out_cr >= 8'd1 && out_cr <= 8'd254));

  // R7: with no luma delay the strobe trails the input by one cycle
  p_y_zero_dly_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dly_y_act == '0) |-> out_y_vld == $past(in_valid));

  // R8: with no chroma delay the strobe trails the input by one cycle
  p_c_zero_dly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dly_c_act == '0) |-> out_c_vld == $past(in_valid));

endmodule

// File: tb/vid_procamp_test.sv
module vid_procamp_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sof, wr_en, dbuf_en;
  logic [7:0] in_y, in_cb, in_cr, wr_data;
  logic [1:0] wr_addr;
  logic       out_y_vld, out_c_vld;
  logic [7:0] out_y, out_cb, out_cr;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  string tag = "R9";

  // bench model of the banks: 0 contrast, 1 setup, 2 saturation, 3 delays
  int m_sh [4];
  int m_act[4];
  int h_v [64];
  int h_y [64];
  int h_cb[64];
  int h_cr[64];

  always #5 clk = ~clk;

  vid_procamp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dbuf_en(dbuf_en),
    .out_y_vld(out_y_vld), .out_y(out_y), .out_c_vld(out_c_vld),
    .out_cb(out_cb), .out_cr(out_cr)
  );

  function automatic int f_clamp(int v);
    if (v < 1) return 1;
    if (v > 254) return 254;
    return v;
  endfunction

  // R1 R2: contrast then signed setup
  function automatic int f_luma(int y, int g, int s);
    int ss = (s >= 128) ? s - 256 : s;
    return f_clamp((y * g) / 128 + ss);
  endfunction

  // R3: saturation about mid-scale, floor rounding
  function automatic int f_chroma(int c, int k);
    int p = (c - 128) * k;
    return f_clamp((p >>> 7) + 128);
  endfunction

  function automatic int f_min(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step();
    int  eff[4];
    int  nsh[4];
    bit  fs;
    int  slot, dy, dc, iy, ic;
    fs = dbuf_en && in_valid && in_sof;
    for (int k = 0; k < 4; k++) eff[k] = fs ? m_sh[k] : m_act[k];
    slot = cyc % 64;
    h_v[slot]  = in_valid;
    h_y[slot]  = f_luma(in_y, eff[0], eff[1]);
    h_cb[slot] = f_chroma(in_cb, eff[2]);
    h_cr[slot] = f_chroma(in_cr, eff[2]);
    for (int k = 0; k < 4; k++) nsh[k] = m_sh[k];
    if (wr_en) nsh[wr_addr] = wr_data;
    if (!dbuf_en)  for (int k = 0; k < 4; k++) m_act[k] = nsh[k];
    else if (fs)   for (int k = 0; k < 4; k++) m_act[k] = m_sh[k];
    for (int k = 0; k < 4; k++) m_sh[k] = nsh[k];
    @(posedge clk);
    @(negedge clk);
    cyc++;
    // R7 R8 R10: outputs come from 1+DY / 1+DC cycles back, delays clamped
    dy = f_min(m_act[3] % 16, 6);
    dc = f_min(m_act[3] / 16, 8);
    iy = cyc - 1 - dy;
    ic = cyc - 1 - dc;
    if (iy < 0) chk("luma strobe", out_y_vld, 0);
    else begin
      chk("luma strobe", out_y_vld, h_v[iy % 64]);
      if (h_v[iy % 64] != 0) chk("luma value", out_y, h_y[iy % 64]);
    end
    if (ic < 0) chk("chroma strobe", out_c_vld, 0);
    else begin
      chk("chroma strobe", out_c_vld, h_v[ic % 64]);
      if (h_v[ic % 64] != 0) begin
        chk("cb value", out_cb, h_cb[ic % 64]);
        chk("cr value", out_cr, h_cr[ic % 64]);
      end
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_sof = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic write(int a, int d);
    idle_inputs();
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    step();
  endtask

  task automatic sample(int y, int cb, int cr, bit sof);
    idle_inputs();
    in_valid = 1; in_sof = sof;
    in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    step();
  endtask

  task automatic random_cycles(int n, bit buffered);
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom % 4) != 0;
      in_sof   = ($urandom % 40) == 0;
      in_y     = 8'($urandom);
      in_cb    = 8'($urandom);
      in_cr    = 8'($urandom);
      wr_en    = ($urandom % 6) == 0;
      wr_addr  = 2'($urandom);
      wr_data  = 8'($urandom);
      if (buffered && in_valid && in_sof) wr_en = 0;
      step();
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sh[0] = 128; m_sh[1] = 0; m_sh[2] = 128; m_sh[3] = 0;
    for (int k = 0; k < 4; k++) m_act[k] = m_sh[k];
    for (int k = 0; k < 64; k++) h_v[k] = 0;
    rst_n = 0; dbuf_en = 0;
    in_y = 0; in_cb = 0; in_cr = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: strobes low after reset, defaults act as identity
    tag = "R9";
    chk("luma strobe after reset", out_y_vld, 0);
    chk("chroma strobe after reset", out_c_vld, 0);
    sample(100, 60, 200, 0);
    sample(0, 255, 0, 0);
    sample(254, 128, 1, 1);
    repeat (3) step();

    // R4: saturation corners with unbuffered writes
    tag = "R4";
    write(0, 255); write(2, 255);
    sample(255, 0, 255, 0);
    write(1, 128);
    sample(0, 128, 129, 0);
    write(1, 127); write(0, 0);
    sample(200, 3, 252, 0);
    repeat (3) step();

    // R7 R8: delay fields above the maximum clamp
    tag = "R7 R8";
    write(3, 255);
    for (int i = 0; i < 12; i++) sample(i * 20, 255 - i * 20, i * 19, 0);
    write(3, 8'h35);
    for (int i = 0; i < 12; i++) sample(i * 7, i * 9, i * 11, 0);

    // R1 R2 R3 R6 R10: random traffic, unbuffered
    tag = "R1 R2 R3 R6 R10";
    random_cycles(3000, 0);

    // R5: buffered writes, directed then random
    tag = "R5";
    dbuf_en = 1;
    write(0, 64); write(1, 10);
    sample(100, 100, 100, 0);
    sample(100, 100, 100, 0);
    sample(100, 100, 100, 1);
    sample(100, 100, 100, 0);
    random_cycles(3000, 1);

    dbuf_en = 0;
    tag = "R6";
    random_cycles(200, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule